// File: doc/BRIEF.md
# Three-Wire Register Serial Master

This block is the master of a three-wire register bus. The bus has an active-low select, a serial clock and one data line that both ends drive. A host raises `req` with a 7-bit register address, a direction flag and, for writes, a 16-bit word. The master then frames the transfer and toggles the clock at a programmable rate. For a read it hands the data line to the slave and collects the 16-bit reply. At the end it pulses `done`, and on a read the result is then on `rdata`. The block also drives a separate active-low reset output to the slave, which is released once the master leaves reset.

Every transfer opens with two dummy clock pulses while the select is still high, because the slave needs them. A frame always begins with a zero lead bit, then a direction bit (1 = read, 0 = write), then the address MSB first. A write appends the data word and closes at once. A read adds one spare clock while the master still drives the line. The master then releases the line for sixteen input clocks, takes the line back and closes the select. The data line is exposed as separate output, output-enable and input pins, so the tristate buffer sits outside the block.

States: `ST_IDLE` goes to `ST_PRE_LO` on `req`. `ST_PRE_LO` and `ST_PRE_HI` alternate for the two preamble pulses, then go to `ST_TX_LO`. `ST_TX_LO` and `ST_TX_HI` alternate once per frame bit. After the last bit a write goes to `ST_DONE` and a read goes to `ST_XT_LO`. `ST_XT_LO` leads to `ST_XT_HI`, the spare clock, which leads to `ST_RX_LO`. `ST_RX_LO` and `ST_RX_HI` alternate for the sixteen input bits, then go to `ST_RETAKE`. `ST_RETAKE` goes to `ST_DONE`, and `ST_DONE` returns to `ST_IDLE` after one cycle. Every state except `ST_IDLE` and `ST_DONE` lasts one half-period.

Top module: `mxs_master`

## Requirements
- R1: While idle and after reset, `sen_n` is 1, `sclk` is 0, `sdata_oe` is 1 and `sdata_o` is 0; `busy` and `done` are 0.
- R2: Each transfer begins with exactly two rising edges of `sclk` while `sen_n` is 1. `sen_n` falls only after them, and no `sclk` pulse occurs with `sen_n` high after it has fallen.
- R3: Frame bits go out MSB first. `sdata_o` changes only while `sclk` is low, and each bit gets one high-then-low `sclk` pulse.
- R4: A write sends 25 bits: bit 24 = 0, bit 23 = 0 (write), bits 22..16 = address, bits 15..0 = `wdata`.
- R5: After the 25th write bit, `sen_n` rises as `sclk` falls, with no further clock pulse.
- R6: A read sends 9 bits (0, then 1, then the address) and then one more `sclk` pulse with `sdata_oe` still 1, for 10 driven pulses in all.
- R7: During a read, `sdata_oe` is 0 for exactly 16 `sclk` pulses, and only while `sen_n` is 0. `sdata_i` is captured as each of these pulses falls, the first captured bit becoming `rdata[15]`.
- R8: After the 16 read bits, `sdata_oe` returns to 1 for one half-period before `sen_n` rises.
- R9: `srst_n` is 0 while `rst_n` is low and 1 from the first clock after reset is released.
- R10: `done` is a one-cycle pulse at the end of each transfer. `req` is ignored while `busy` is 1.
- R11: Each half-period of `sclk` lasts `div_half` clock cycles, with 0 treated as 1, taken when the request is accepted. A write's `done` comes 54·D cycles after acceptance and a read's 57·D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | 8 | Clock cycles per `sclk` half-period |
| req | input | 1 | Start a transfer (taken when idle) |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 16 | Last read result |
| sen_n | output | 1 | Active-low bus select |
| sclk | output | 1 | Serial clock |
| sdata_o | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line output enable |
| sdata_i | input | 1 | Data line input value |
| srst_n | output | 1 | Active-low reset to the slave |

## Verification
A wrong bit counter or a wrong state transition shows up on the bus as a wrong number of `sclk` pulses within the transfer. It may be the preamble count, the frame length or the read pulse count, and each of these is seen when the select rises. A fault in the turnaround shows up as `sdata_oe` changing on the wrong pulse, which is visible on the first read clock or at the select's rising edge. A divider or a skipped state moves the `done` pulse by a whole number of half-periods, so comparing against the cycle count catches it at the end of the same transfer.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_LO,
        ST_PRE_HI,
        ST_TX_LO,
        ST_TX_HI,
        ST_XT_LO,
        ST_XT_HI,
        ST_RX_LO,
        ST_RX_HI,
        ST_RETAKE,
        ST_DONE
    } mxs_state_e;
endpackage

// File: rtl/mxs_tick.sv
module mxs_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (div_half == '0) ? '0 : div_half - 1'b1;
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == limit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mxs_shift.sv
module mxs_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], ser_in};
    end
endmodule

// File: rtl/mxs_master.sv
module mxs_master
    import mxs_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 16,
    parameter int DIV_W    = 8,
    parameter int PRE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              req,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sen_n,
    output logic              sclk,
    output logic              sdata_o,
    output logic              sdata_oe,
    input  logic              sdata_i,
    output logic              srst_n
);
    localparam int WR_BITS = 2 + ADDR_W + DATA_W;
    localparam int RD_BITS = 2 + ADDR_W;
    localparam int CNT_W   = $clog2(WR_BITS + 1);

    mxs_state_e        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DIV_W-1:0]  div_q;
    logic              rd_q;
    logic              tick, run, accept, last;
    logic [WR_BITS-1:0] tx_q, tx_init;

    assign accept = (state == ST_IDLE) && req;
    assign run    = (state != ST_IDLE) && (state != ST_DONE);
    assign last   = (bit_cnt == CNT_W'(1));
    assign tx_init = rd ? {2'b01, addr, {DATA_W{1'b0}}}
                        : {2'b00, addr, wdata};

    mxs_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .div_half(div_q), .tick(tick)
    );

    mxs_shift #(.W(WR_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(tx_init),
        .shift(tick && state == ST_TX_HI), .ser_in(1'b0), .q(tx_q)
    );

    mxs_shift #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
        .shift(tick && state == ST_RX_HI), .ser_in(sdata_i), .q(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            srst_n <= 1'b0;
        else
            srst_n <= 1'b1;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            div_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                rd_q    <= rd;
                div_q   <= div_half;
                bit_cnt <= CNT_W'(PRE_CLKS);
            end else if (tick) begin
                unique case (state)
                    ST_PRE_HI: bit_cnt <= last ? (rd_q ? CNT_W'(RD_BITS) : CNT_W'(WR_BITS))
                                               : bit_cnt - 1'b1;
                    ST_TX_HI:  bit_cnt <= bit_cnt - 1'b1;
                    ST_XT_HI:  bit_cnt <= CNT_W'(DATA_W);
                    ST_RX_HI:  bit_cnt <= bit_cnt - 1'b1;
                    default:   bit_cnt <= bit_cnt;
                endcase
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req)  state_nx = ST_PRE_LO;
            ST_PRE_LO: if (tick) state_nx = ST_PRE_HI;
            ST_PRE_HI: if (tick) state_nx = last ? ST_TX_LO : ST_PRE_LO;
            ST_TX_LO:  if (tick) state_nx = ST_TX_HI;
            ST_TX_HI:  if (tick) state_nx = last ? (rd_q ? ST_XT_LO : ST_DONE) : ST_TX_LO;
            ST_XT_LO:  if (tick) state_nx = ST_XT_HI;
            ST_XT_HI:  if (tick) state_nx = ST_RX_LO;
            ST_RX_LO:  if (tick) state_nx = ST_RX_HI;
            ST_RX_HI:  if (tick) state_nx = last ? ST_RETAKE : ST_RX_LO;
            ST_RETAKE: if (tick) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sen_n    = 1'b0;
        sclk     = 1'b0;
        sdata_o  = 1'b0;
        sdata_oe = 1'b1;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:   begin sen_n = 1'b1; busy = 1'b0; end
            ST_PRE_LO: sen_n = 1'b1;
            ST_PRE_HI: begin sen_n = 1'b1; sclk = 1'b1; end
            ST_TX_LO:  sdata_o = tx_q[WR_BITS-1];
            ST_TX_HI:  begin sclk = 1'b1; sdata_o = tx_q[WR_BITS-1]; end
            ST_XT_LO:  ;
            ST_XT_HI:  sclk = 1'b1;
            ST_RX_LO:  sdata_oe = 1'b0;
            ST_RX_HI:  begin sdata_oe = 1'b0; sclk = 1'b1; end
            ST_RETAKE: ;
            ST_DONE:   begin sen_n = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/mxs_checker.sv
module mxs_checker (
    input logic clk,
    input logic rst_n,
    input logic sen_n,
    input logic sclk,
    input logic sdata_o,
    input logic sdata_oe,
    input logic busy,
    input logic done,
    input logic srst_n
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sen_n && !sclk && sdata_oe && !sdata_o && !done)); // R1
    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && sdata_oe && $past(sdata_oe)) |-> $stable(sdata_o)); // R3
    AST_SEL_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_n) |-> !sclk); // R5
    AST_RELEASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> (!sen_n && busy)); // R7
    AST_RETAKE_BEFORE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_n) |-> (sdata_oe && $past(sdata_oe))); // R8
    AST_SLAVE_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> srst_n); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10
endmodule

bind mxs_master mxs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .busy(busy), .done(done), .srst_n(srst_n)
);

// File: tb/tb_mxs_master.sv
`timescale 1ns/100ps
module tb_mxs_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_half = 8'd1;
    logic        req = 1'b0;
    logic        rd = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, sen_n, sclk, sdata_o, sdata_oe, srst_n;
    logic [15:0] rdata;
    logic        sdata_i = 1'b0;

    int total = 0;
    int fails = 0;

    // bus monitor state
    int          pre_cnt, tx_cnt, rx_cnt, late_pre, bad_close;
    logic [31:0] tx_bits;
    logic [15:0] slv_word;
    bit          en_seen;

    always #2.5 clk = ~clk;

    mxs_master dut (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .req(req), .rd(rd),
        .addr(addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .sen_n(sen_n), .sclk(sclk), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
        .sdata_i(sdata_i), .srst_n(srst_n)
    );

    always @(posedge sclk) begin
        if (sen_n) begin
            pre_cnt++;
            if (en_seen) late_pre++;
        end else if (sdata_oe) begin
            tx_cnt++;
            tx_bits = {tx_bits[30:0], sdata_o};
        end else begin
            rx_cnt++;
            sdata_i = slv_word[15];
            slv_word = {slv_word[14:0], 1'b0};
        end
    end
    always @(negedge sen_n) en_seen = 1'b1;
    always @(posedge sen_n) if (!sdata_oe) bad_close++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        pre_cnt = 0; tx_cnt = 0; rx_cnt = 0; late_pre = 0; bad_close = 0;
        tx_bits = '0; en_seen = 1'b0;
    endtask

    // issues one request; optionally pokes a second request mid-transfer
    task automatic run_txn(input bit r, input [6:0] a, input [15:0] w,
                           input [7:0] d, input bit poke, output int n);
        clear_mon();
        @(negedge clk);
        req = 1'b1; rd = r; addr = a; wdata = w; div_half = d;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req = 1'b0; addr = ~a; wdata = ~w; div_half = d + 8'd3; rd = ~r;
            end
            if (poke && n == 20) begin
                req = 1'b1; rd = 1'b0; addr = 7'h55; wdata = 16'hAAAA;
            end
            if (poke && n == 21) req = 1'b0;
            if (done || n > 20000) break;
        end
    endtask

    task automatic t_reset();
        chk(srst_n == 1'b0, "R9 srst_n low in reset", srst_n, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(srst_n == 1'b1, "R9 srst_n released", srst_n, 1);
        chk({sen_n, sclk, sdata_oe, sdata_o, busy, done} == 6'b101000,
            "R1 idle lines", {sen_n, sclk, sdata_oe, sdata_o, busy, done}, 6'b101000);
    endtask

    task automatic t_write(input [6:0] a, input [15:0] w, input [7:0] d);
        int n, de;
        de = (d == 0) ? 1 : int'(d);
        run_txn(1'b0, a, w, d, 1'b0, n);
        chk(pre_cnt == 2 && late_pre == 0, "R2 preamble pulses", pre_cnt, 2);
        chk(tx_cnt == 25, "R5 write pulse count", tx_cnt, 25);
        chk(tx_bits[24:0] == {2'b00, a, w}, "R4 write frame", tx_bits[24:0], {2'b00, a, w});
        chk(rx_cnt == 0, "R7 no release on write", rx_cnt, 0);
        chk(n == 54 * de + 1, "R11 write duration", n, 54 * de + 1);
        @(negedge clk);
        chk(!done && !busy && sen_n && !sclk, "R10 done single pulse", done, 0);
    endtask

    task automatic t_read(input [6:0] a, input [15:0] word, input [7:0] d);
        int n;
        slv_word = word;
        run_txn(1'b1, a, 16'h0000, d, 1'b0, n);
        chk(pre_cnt == 2 && late_pre == 0, "R2 read preamble", pre_cnt, 2);
        chk(tx_cnt == 10, "R6 driven pulses on read", tx_cnt, 10);
        chk(tx_bits[9:1] == {2'b01, a}, "R6 read header", tx_bits[9:1], {2'b01, a});
        chk(rx_cnt == 16, "R7 input pulses", rx_cnt, 16);
        chk(rdata == word, "R7 read data", rdata, word);
        chk(bad_close == 0 && sdata_oe, "R8 line retaken before close", bad_close, 0);
        chk(n == 57 * int'(d) + 1, "R11 read duration", n, 57 * int'(d) + 1);
        chk(sdata_i == word[0], "R3 slave saw all pulses", sdata_i, word[0]);
    endtask

    task automatic t_busy_ignore();
        int n;
        run_txn(1'b0, 7'h12, 16'h3C5A, 8'd1, 1'b1, n);
        chk(tx_bits[24:0] == {2'b00, 7'h12, 16'h3C5A}, "R10 frame kept while busy",
            tx_bits[24:0], {2'b00, 7'h12, 16'h3C5A});
        chk(n == 55, "R10 duration kept while busy", n, 55);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!busy && sen_n, "R10 no queued request", busy, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write(7'h7F, 16'hA55A, 8'd1);
        t_write(7'h01, 16'h0001, 8'd3);
        t_write(7'h40, 16'h8000, 8'd0);   // R11 zero divider acts as one
        t_read(7'h2B, 16'hC3A5, 8'd2);
        t_read(7'h00, 16'hFFFF, 8'd1);
        t_read(7'h7F, 16'h0001, 8'd1);
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end
endmodule